// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces periodic auto-refresh for a DRAM controller whose core clock can be divided down. A single control word, written and read through a plain register port, carries a 7-bit refresh count and a self-refresh enable. An input strobe marks the core cycles that are really active at the current division ratio. The timer counts only those cycles. Every 64 of them form one count unit. After the programmed number of units it raises a refresh request, and the request stays up until the memory controller acknowledges it.

Software picks the count so that the interval comes close to the DRAM's required spacing at the present clock rate. It rewrites the field with a read-modify-write whenever the clock divisor changes. A rewritten count does not shorten or stretch the period already under way; it is picked up at the next reload. Setting the self-refresh bit stops the periodic requests entirely. While the bit is set, the block drives a self-refresh level to the controller instead.

Top module: `refresh_timer`

## Requirements
- R1: The whole control word is a register. A write replaces it, and from the cycle after the write the read port returns exactly the written word, including the bits the timer does not use.
- R2: The refresh count is held in bits 14 to 8 of the control word, and the self-refresh enable is bit 16. All other bits have no effect on the timer.
- R3: A 6-bit prescaler advances only on cycles where `tickEn` is high. Every 64 enabled cycles it produces one count unit. Cycles with `tickEn` low do not move the timing.
- R4: With a nonzero count N, the first request after reset rises 64·(N+1) enabled cycles after reset is released. Each later request rises 64·N enabled cycles after the one before it.
- R5: `refreshReq` stays high until `refreshAck` is sampled high, and it falls in the cycle after the acknowledge.
- R6: With a count of zero, no request is raised. A period already running when zero is written still ends with its request.
- R7: While bit 16 is set, `selfRefresh` is high from the cycle after the write, any pending request is dropped, and no request is raised. After the bit is cleared, the first request rises 64·(N+1) enabled cycles after the clearing write.
- R8: A new count written in the middle of a period takes effect only at the next reload. The period that is running ends at its original length.
- R9: When a new refresh falls due in the same cycle as an acknowledge of the previous request, the request stays high.
- R10: After reset the control word is zero, and `refreshReq` and `selfRefresh` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the control word |
| cfgWrData | input | 32 | Control word to write |
| cfgRdData | output | 32 | Current control word |
| tickEn | input | 1 | High on active (divided) core cycles |
| refreshReq | output | 1 | Periodic auto-refresh request, held until acknowledged |
| refreshAck | input | 1 | Acknowledge from the DRAM command logic |
| selfRefresh | output | 1 | Self-refresh level, high while the enable bit is set |

## Verification
Two functions can land in the same cycle: the acknowledge that clears an outstanding request, and the expiry that raises the next one. The bench provokes this by programming a count of one and leaving the first request unacknowledged. It then drives the acknowledge exactly on the edge where the second expiry occurs. It expects the request to be still high after that edge and low only after a further acknowledge edge. Every request rise is also matched against a queue of expected enabled-cycle stamps, so an extra or lost request is reported as a mismatch.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  // Prescaler commands from control to datapath
  typedef struct packed {
    logic step;   // advance one enabled cycle
    logic clear;  // force back to zero
  } preStrobe_t;

  // Refresh counter commands from control to datapath
  typedef struct packed {
    logic load;   // take the reload value
    logic dec;    // count one unit down
    logic clear;  // force back to zero
  } cntStrobe_t;

endpackage

// File: rtl/rtimer_datapath.sv
module rtimer_datapath
  import rtimer_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  preStrobe_t       preStb,
  input  cntStrobe_t       cntStb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             preWrap,
  output logic             cntIsZero,
  output logic             cntIsOne
);

  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] unitCnt;

  // Prescaler: one unit per 2**PRE_W enabled cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              preCnt <= '0;
    else if (preStb.clear)  preCnt <= '0;
    else if (preStb.step)   preCnt <= preCnt + PRE_W'(1);
  end

  assign preWrap = preStb.step && (preCnt == PRE_MAX);

  // Refresh unit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              unitCnt <= '0;
    else if (cntStb.clear)  unitCnt <= '0;
    else if (cntStb.load)   unitCnt <= reloadVal;
    else if (cntStb.dec)    unitCnt <= unitCnt - CNT_ONE;
  end

  assign cntIsZero = (unitCnt == '0);
  assign cntIsOne  = (unitCnt == CNT_ONE);

  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    preWrap && !preStb.clear |=> preCnt == '0); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cntIsZero && !cntStb.load |=> cntIsZero); // R6

endmodule

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              CNT_LSB    = 8,
  parameter int              CNT_W      = 7,
  parameter int              SR_BIT     = 16,
  parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              tickEn,
  input  logic              refreshAck,
  input  logic              preWrap,
  input  logic              cntIsZero,
  input  logic              cntIsOne,
  output preStrobe_t        preStb,
  output cntStrobe_t        cntStb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              refreshReq,
  output logic              selfRefresh
);

  logic [DATA_W-1:0] ctrlWord;
  logic              srOn;
  logic              dueNow;
  logic              reqQ;

  // Control word: whole word held so readback matches the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlWord <= RESET_WORD;
    else if (cfgWrEn) ctrlWord <= cfgWrData;
  end

  assign cfgRdData = ctrlWord;
  assign srOn      = ctrlWord[SR_BIT];
  assign reloadVal = ctrlWord[CNT_LSB +: CNT_W];

  // Strobes to the datapath
  always_comb begin
    preStb.clear = srOn;
    preStb.step  = tickEn && !srOn;
    cntStb.clear = srOn;
    // reload on expiry, and keep polling the field while idle at zero
    cntStb.load  = preWrap && (cntIsZero || cntIsOne);
    cntStb.dec   = preWrap && !cntIsZero && !cntIsOne;
  end

  assign dueNow = preWrap && cntIsOne;

  // Request level: a new expiry outranks a same-cycle acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           reqQ <= 1'b0;
    else if (srOn)       reqQ <= 1'b0;
    else if (dueNow)     reqQ <= 1'b1;
    else if (refreshAck) reqQ <= 1'b0;
  end

  assign refreshReq  = reqQ;
  assign selfRefresh = srOn;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && !refreshAck && !selfRefresh |=> refreshReq); // R5

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && refreshAck && !dueNow |=> !refreshReq); // R5

  AST_DUE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    dueNow |=> refreshReq); // R9

  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |=> !refreshReq); // R7

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == $past(cfgWrData)); // R1

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshReq) |-> $past(tickEn)); // R3

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rtimer_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                CNT_LSB    = 8,
  parameter int                CNT_W      = 7,
  parameter int                SR_BIT     = 16,
  parameter int                PRE_W      = 6,
  parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              tickEn,
  output logic              refreshReq,
  input  logic              refreshAck,
  output logic              selfRefresh
);

  preStrobe_t       preStb;
  cntStrobe_t       cntStb;
  logic [CNT_W-1:0] reloadVal;
  logic             preWrap;
  logic             cntIsZero;
  logic             cntIsOne;

  rtimer_ctrl #(
    .DATA_W(DATA_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W),
    .SR_BIT(SR_BIT), .RESET_WORD(RESET_WORD)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .tickEn(tickEn), .refreshAck(refreshAck),
    .preWrap(preWrap), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne),
    .preStb(preStb), .cntStb(cntStb), .reloadVal(reloadVal),
    .refreshReq(refreshReq), .selfRefresh(selfRefresh)
  );

  rtimer_datapath #(
    .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN),
    .preStb(preStb), .cntStb(cntStb), .reloadVal(reloadVal),
    .preWrap(preWrap), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );

endmodule

// File: tb/refresh_timer_test.sv
`timescale 1ns/1ps
module refresh_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        tickEn = 1'b1;
  logic        refreshReq;
  logic        refreshAck;
  logic        selfRefresh;

  logic        ackAuto = 1'b0;
  logic        ackDrv = 1'b0;
  logic        ackManual = 1'b0;
  int          tickMode = 0;
  int          phase = 0;
  int          enCount = 0;
  bit          prevReq = 1'b0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;
  string       curTag = "R4";
  int          expQ[$];

  assign refreshAck = ackDrv | ackManual;

  always #4 clk = ~clk;

  refresh_timer uut (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .tickEn(tickEn), .refreshReq(refreshReq), .refreshAck(refreshAck),
    .selfRefresh(selfRefresh)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // enabled-cycle stamp, counted on the same edges the prescaler sees
  always @(posedge clk) begin
    if (!rstN) enCount <= 0;
    else if (tickEn) enCount <= enCount + 1;
  end

  // tick pattern driver
  always @(negedge clk) begin
    phase <= phase + 1;
    tickEn <= (tickMode == 0) ? 1'b1 : ((phase % 3) != 0);
  end

  // monitor: match each request rise against the expected stamps
  always @(negedge clk) begin
    if (rstN) begin
      if (refreshReq && !prevReq) begin
        if (expQ.size() == 0) check(1'b0, curTag, "unexpected request at stamp", enCount, -1);
        else begin
          int e;
          e = expQ.pop_front();
          check(enCount == e, curTag, "request rise stamp", enCount, e);
        end
      end
      prevReq <= refreshReq;
      ackDrv <= ackAuto && refreshReq;
    end else begin
      prevReq <= 1'b0;
      ackDrv <= 1'b0;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    ackAuto = 1'b0;
    ackManual = 1'b0;
    expQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeWord(logic [31:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitEn(int n);
    while (enCount < n) @(negedge clk);
  endtask

  task automatic expectEmpty(string tag);
    check(expQ.size() == 0, tag, "expected requests still missing", expQ.size(), 0);
  endtask

  function automatic logic [31:0] mkWord(int cnt, bit sr);
    logic [31:0] w;
    w = '0;
    w[14:8] = cnt[6:0];
    w[16] = sr;
    return w;
  endfunction

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int base;
    // R10: reset state
    doReset();
    @(negedge clk);
    check(cfgRdData == 0, "R10", "word after reset", cfgRdData, 0);
    check(refreshReq == 0, "R10", "request after reset", refreshReq, 0);
    check(selfRefresh == 0, "R10", "self-refresh after reset", selfRefresh, 0);

    // R1 / R2: full word readback, unused bits have no effect
    curTag = "R2";
    writeWord(32'h5A5A_2A3C);
    check(cfgRdData == 32'h5A5A_2A3C, "R1", "readback", cfgRdData, 32'h5A5A_2A3C);
    check(selfRefresh == 0, "R2", "bit16 clear means no self-refresh", selfRefresh, 0);
    waitEn(40);
    check(refreshReq == 0, "R2", "no early request", refreshReq, 0);

    // R4: periodic requests, count 3, every cycle enabled
    doReset();
    curTag = "R4";
    ackAuto = 1'b1;
    writeWord(mkWord(3, 0));
    expQ.push_back(256); expQ.push_back(448); expQ.push_back(640);
    waitEn(700);
    expectEmpty("R4");

    // R3: only enabled cycles count, count 2, two of three cycles enabled
    doReset();
    curTag = "R3";
    tickMode = 1;
    ackAuto = 1'b1;
    writeWord(mkWord(2, 0));
    expQ.push_back(192); expQ.push_back(320); expQ.push_back(448);
    waitEn(500);
    expectEmpty("R3");
    tickMode = 0;

    // R8 then R6: mid-period change waits for reload, zero stops requests
    doReset();
    curTag = "R8";
    ackAuto = 1'b1;
    writeWord(mkWord(4, 0));
    expQ.push_back(320);
    waitEn(100);
    writeWord(mkWord(1, 0));
    expQ.push_back(384); expQ.push_back(448);
    waitEn(470);
    expectEmpty("R8");
    curTag = "R6";
    writeWord(mkWord(0, 0));
    expQ.push_back(512);   // period running under count 1 still completes
    waitEn(1300);
    expectEmpty("R6");
    check(refreshReq == 0, "R6", "no request with zero count", refreshReq, 0);

    // R5 and R9: hold until acknowledge, expiry outranks same-cycle ack
    doReset();
    curTag = "R5";
    writeWord(mkWord(1, 0));
    expQ.push_back(128);
    waitEn(150);
    check(refreshReq == 1, "R5", "request held without ack", refreshReq, 1);
    expectEmpty("R5");
    waitEn(191);
    ackManual = 1'b1;       // sampled on the edge of the second expiry
    @(negedge clk);
    check(refreshReq == 1, "R9", "request after ack on expiry edge", refreshReq, 1);
    @(negedge clk);
    check(refreshReq == 0, "R5", "request after plain ack", refreshReq, 0);
    ackManual = 1'b0;

    // R7: self-refresh drops pending request and silences the timer
    doReset();
    curTag = "R7";
    writeWord(mkWord(1, 0));
    expQ.push_back(128);
    waitEn(140);
    check(refreshReq == 1, "R7", "request pending before self-refresh", refreshReq, 1);
    writeWord(mkWord(2, 1));
    check(selfRefresh == 1, "R7", "self-refresh level", selfRefresh, 1);
    @(negedge clk);
    check(refreshReq == 0, "R7", "pending request dropped", refreshReq, 0);
    waitEn(700);
    check(selfRefresh == 1, "R7", "self-refresh still held", selfRefresh, 1);
    writeWord(mkWord(2, 0));
    base = enCount;
    check(selfRefresh == 0, "R7", "self-refresh released", selfRefresh, 0);
    ackAuto = 1'b1;
    expQ.push_back(base + 192);
    waitEn(base + 260);
    expectEmpty("R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule